// File: doc/BRIEF.md
# Event-Driven Timer with Prescaler

A single 16-bit up-counting timer that a host programs through a small register file. A power-of-two prescaler sits in front of the counter. It is fed either by every peripheral clock cycle or by edges on one line of a 64-line synchronous event bus. The line is picked by a 6-bit index, and a polarity bit says which edge counts. Each time the prescaler completes a full division, it hands the counter one step.

The counter is compared with a programmable target, and the timer raises a one-cycle event output when the compare hits. In one-shot mode the timer runs up to the target, fires once and then parks. In continuous mode it runs from zero to target minus one, wraps, and fires every time it lands back on zero. Writing the enable bit as 1 restarts the count from zero. The target may be rewritten while the timer runs.

Top module: `evt_timer`

## Requirements
- R1: After reset every register reads 0 and the event output is low.
- R2: Register map (byte offsets, 4-bit address, 32-bit data). 0x0 is configuration: bit0 selects the reload behaviour (1 = continuous, 0 = one-shot), bit1 selects the prescaler source (1 = bus tick, 0 = clock), bits 7:4 are the prescaler exponent, bits 13:8 are the tick line index and bit14 is the tick polarity. 0x4 is control, with enable at bit0. 0x8 holds the target in bits 15:0. 0xC is the read-only counter. Unused bits read 0, and writes to 0xC or to any other offset change nothing.
- R3: A control write with bit0 = 1 clears the counter and the prescaler in the next cycle and produces no event. A control write with bit0 = 0 stops stepping, and the counter holds its value.
- R4: With exponent p, the counter steps once per 2^p source pulses, counted from the restart.
- R5: In tick mode, a source pulse is a change of the selected bus line between two consecutive clock samples. The change counts when it is rising if bit14 = 0, and when it is falling if bit14 = 1. Changes on other lines have no effect.
- R6: In one-shot mode each step adds 1. The step that makes the counter equal to or greater than the target raises the event for exactly the cycle in which the counter first shows that value. Counting then stops, no further events follow, and enable still reads 1.
- R7: In one-shot mode with target 0 the counter goes to 1, and a single one-cycle event is produced.
- R8: In continuous mode the counter steps through 0 to target-1 and then returns to 0. The event is high in each cycle in which the counter has just returned to 0.
- R9: In continuous mode with a target of 0 or 1 the counter stays at 0 and every step raises the event. Clocked with exponent 0, the event is high from the cycle after enable and stays high.
- R10: A target written while the timer runs is used from the next step on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write byte offset |
| wrData | input | 32 | Register write data |
| rdAddr | input | 4 | Register read byte offset |
| rdData | output | 32 | Register read data (combinational from rdAddr) |
| evtBus | input | 64 | Synchronous event bus carrying the tick lines |
| evtOut | output | 1 | One-cycle timer event |

## Verification
A register write takes effect at the clock edge that samples it. A restart therefore shows a zero counter at the next edge, and the first step lands at the edge after that. A bus-line change driven before an edge is detected at that same edge, and it steps the counter there when it completes a prescaler division. The event output is a register that is set by the same edge that loads the terminal or wrapped counter value, so evtOut and the counter readback are due in the same cycle. The bench drives inputs on the falling edge and advances its behavioural model at each rising edge. One time unit after that edge it compares both evtOut and the read data of the currently addressed register against the model.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int CNT_W  = 16;
  localparam int SEL_W  = 6;
  localparam int PRE_W  = 4;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int BUS_W  = 1 << SEL_W;
  localparam int PRE_CNT_W = (1 << PRE_W) - 1;

  localparam logic [ADDR_W-1:0] ADDR_CFG = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_CTL = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_TGT = 4'h8;
  localparam logic [ADDR_W-1:0] ADDR_CNT = 4'hC;

  typedef struct packed {
    logic restart;
    logic step;
  } tmr_strobe_t;

  typedef struct packed {
    logic             tickPol;
    logic [SEL_W-1:0] tickSel;
    logic [PRE_W-1:0] preExp;
    logic             tickMode;
    logic             contMode;
  } tmr_cfg_t;
endpackage

// File: rtl/evt_timer_ctrl.sv
module evt_timer_ctrl
  import evt_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [BUS_W-1:0]  evtBus,
  input  logic [CNT_W-1:0]  cnt,
  output tmr_cfg_t          cfg,
  output logic [CNT_W-1:0]  target,
  output tmr_strobe_t       strobe
);
  tmr_cfg_t               cfgQ;
  logic                   enQ;
  logic [CNT_W-1:0]       targetQ;
  logic                   selPrev;
  logic [PRE_CNT_W-1:0]   preCnt;
  logic [PRE_CNT_W-1:0]   preLimit;
  logic                   wrCfg, wrCtl, wrTgt;
  logic                   selNow, tickEdge, srcPulse, preLast;
  logic                   wrDataUnused;

  assign wrCfg = wrEn && (wrAddr == ADDR_CFG);
  assign wrCtl = wrEn && (wrAddr == ADDR_CTL);
  assign wrTgt = wrEn && (wrAddr == ADDR_TGT);
  assign wrDataUnused = ^{wrData[DATA_W-1:15], wrData[3:2]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= '0;
      enQ     <= 1'b0;
      targetQ <= '0;
      selPrev <= 1'b0;
    end else begin
      if (wrCfg) begin
        cfgQ.contMode <= wrData[0];
        cfgQ.tickMode <= wrData[1];
        cfgQ.preExp   <= wrData[7:4];
        cfgQ.tickSel  <= wrData[13:8];
        cfgQ.tickPol  <= wrData[14];
      end
      if (wrCtl) enQ <= wrData[0];
      if (wrTgt) targetQ <= wrData[CNT_W-1:0];
      selPrev <= selNow;
    end
  end

  // Tick selection and edge detection
  assign selNow   = evtBus[cfgQ.tickSel];
  assign tickEdge = cfgQ.tickPol ? (selPrev & ~selNow) : (~selPrev & selNow);
  assign srcPulse = cfgQ.tickMode ? tickEdge : 1'b1;

  // Power-of-two prescaler
  assign preLimit = ~({PRE_CNT_W{1'b1}} << cfgQ.preExp);
  assign preLast  = (preCnt >= preLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (strobe.restart) begin
      preCnt <= '0;
    end else if (enQ && srcPulse) begin
      preCnt <= preLast ? '0 : preCnt + 1'b1;
    end
  end

  assign strobe.restart = wrCtl & wrData[0];
  assign strobe.step    = enQ & srcPulse & preLast;
  assign cfg            = cfgQ;
  assign target         = targetQ;

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_CFG: rdData = {17'd0, cfgQ.tickPol, cfgQ.tickSel, cfgQ.preExp,
                          2'b00, cfgQ.tickMode, cfgQ.contMode};
      ADDR_CTL: rdData = {{(DATA_W-1){1'b0}}, enQ};
      ADDR_TGT: rdData = {{(DATA_W-CNT_W){1'b0}}, targetQ};
      ADDR_CNT: rdData = {{(DATA_W-CNT_W){1'b0}}, cnt};
      default:  rdData = '0;
    endcase
  end

  AST_RESTART_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> enQ); // R3

  AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && cfgQ.preExp != '0 && !strobe.restart) |=>
      (!strobe.step || cfgQ.preExp == '0)); // R4

  AST_CNT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_CNT) |=> ($stable(cfgQ) && $stable(targetQ))); // R2
endmodule

// File: rtl/evt_timer_dp.sv
module evt_timer_dp
  import evt_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tmr_strobe_t      strobe,
  input  logic             contMode,
  input  logic [CNT_W-1:0] target,
  output logic [CNT_W-1:0] cnt,
  output logic             evt
);
  logic done;
  logic hit;
  logic stalled;

  // One comparator serves both modes: next value reaches the target
  assign hit     = ({1'b0, cnt} + 1'b1) >= {1'b0, target};
  assign stalled = done & ~contMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      done <= 1'b0;
      evt  <= 1'b0;
    end else if (strobe.restart) begin
      cnt  <= '0;
      done <= 1'b0;
      evt  <= 1'b0;
    end else begin
      evt <= 1'b0;
      if (strobe.step && !stalled) begin
        if (hit) begin
          evt <= 1'b1;
          if (contMode) begin
            cnt <= '0;
          end else begin
            cnt  <= cnt + 1'b1;
            done <= 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (cnt == '0 && !evt)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.step && !strobe.restart) |=> $stable(cnt)); // R3

  AST_ONE_SHOT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (evt && !contMode) |=> (!evt || contMode)); // R6

  AST_ONE_SHOT_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    (stalled && !strobe.restart) |=> $stable(cnt)); // R6

  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (evt && contMode && $past(contMode)) |-> (cnt == '0)); // R8

  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.restart && !stalled && !hit) |=>
      (cnt == CNT_W'($past(cnt) + 1'b1))); // R6
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [BUS_W-1:0]  evtBus,
  output logic              evtOut
);
  tmr_cfg_t         cfg;
  tmr_strobe_t      strobe;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cnt;

  evt_timer_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .evtBus (evtBus),
    .cnt    (cnt),
    .cfg    (cfg),
    .target (target),
    .strobe (strobe)
  );

  evt_timer_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .contMode (cfg.contMode),
    .target   (target),
    .cnt      (cnt),
    .evt      (evtOut)
  );
endmodule

// File: tb/tb_evt_timer.sv
`timescale 1ns/100ps
module tb_evt_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = 4'h0;
  logic [31:0] wrData = 32'h0;
  logic [3:0]  rdAddr = 4'hC;
  logic [31:0] rdData;
  logic [63:0] evtBus = 64'h0;
  logic        evtOut;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;
  string curReq = "R1";

  // behavioural model state
  int mEn, mCnt, mDone, mEvt, mPrevSel, mPulses;
  int mCont, mMode, mPre, mSel, mPol, mTgt;

  always #2.5 clk = ~clk;

  evt_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evtBus(evtBus), .evtOut(evtOut)
  );

  function automatic logic [31:0] modelRead(input logic [3:0] a);
    case (a)
      4'h0: return 32'(mCont) | (32'(mMode) << 1) | (32'(mPre) << 4) |
                   (32'(mSel) << 8) | (32'(mPol) << 14);
      4'h4: return 32'(mEn);
      4'h8: return 32'(mTgt);
      4'hC: return 32'(mCnt);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    int lineNow, edgeSeen, src, step, nCnt, nDone, nEvt;
    if (!rstN) begin
      mEn = 0; mCnt = 0; mDone = 0; mEvt = 0; mPrevSel = 0; mPulses = 0;
      mCont = 0; mMode = 0; mPre = 0; mSel = 0; mPol = 0; mTgt = 0;
    end else begin
      lineNow  = int'(evtBus[mSel]);
      edgeSeen = mPol ? int'(mPrevSel == 1 && lineNow == 0)
                      : int'(mPrevSel == 0 && lineNow == 1);
      src  = mMode ? edgeSeen : 1;
      step = 0;
      if (mEn != 0 && src != 0) begin
        mPulses = mPulses + 1;
        if (mPulses % (1 << mPre) == 0) step = 1;
      end
      nCnt = mCnt; nDone = mDone; nEvt = 0;
      if (step != 0 && !(mDone != 0 && mCont == 0)) begin
        if (mCont != 0) begin
          if (mCnt + 1 >= mTgt) begin nCnt = 0; nEvt = 1; end
          else nCnt = mCnt + 1;
        end else begin
          nCnt = mCnt + 1;
          if (nCnt >= mTgt) begin nEvt = 1; nDone = 1; end
        end
      end
      mPrevSel = lineNow;
      if (wrEn) begin
        case (wrAddr)
          4'h0: begin
            mCont = int'(wrData[0]); mMode = int'(wrData[1]);
            mPre = int'(wrData[7:4]); mSel = int'(wrData[13:8]);
            mPol = int'(wrData[14]);
          end
          4'h4: begin
            mEn = int'(wrData[0]);
            if (wrData[0]) begin nCnt = 0; nDone = 0; nEvt = 0; mPulses = 0; end
          end
          4'h8: mTgt = int'(wrData[15:0]);
          default: ;
        endcase
      end
      mCnt = nCnt; mDone = nDone; mEvt = nEvt;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rstN && !finished) begin
      vectors++;
      if (rdData !== modelRead(rdAddr) || evtOut !== mEvt[0]) begin
        fails++;
        $display("FAIL %s addr=%h rdData=%h expected %h evtOut=%b expected %0d",
                 curReq, rdAddr, rdData, modelRead(rdAddr), evtOut, mEvt);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk);
    rdAddr = a;
  endtask

  task automatic pulseLine(input int idx, input int gap);
    @(negedge clk); evtBus[idx] = ~evtBus[idx];
    idle(gap);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    // R1: reset values on every offset
    curReq = "R1";
    rd(4'h0); rd(4'h4); rd(4'h8); rd(4'hC); rd(4'h6);
    // R2: field packing, reserved bits, read-only counter
    curReq = "R2";
    rdAddr = 4'h0;
    wr(4'h0, 32'hFFFF_FFFF); idle(1);
    wr(4'h8, 32'hFFFF_1234); rd(4'h8); idle(1);
    wr(4'hC, 32'h0000_00AA); rd(4'hC); idle(1);
    wr(4'h2, 32'hFFFF_FFFF); rd(4'h0); idle(1); rd(4'h4); idle(1);
    wr(4'h0, 32'h0); rd(4'hC);
    // R6: one-shot run to target 5
    curReq = "R6";
    wr(4'h8, 32'd5); wr(4'h4, 32'd1); idle(10);
    rd(4'h4); idle(2); rd(4'hC);
    // R7: one-shot with target 0
    curReq = "R7";
    wr(4'h8, 32'd0); wr(4'h4, 32'd1); idle(6);
    // R8: continuous wrap with target 4
    curReq = "R8";
    wr(4'h0, 32'h1); wr(4'h8, 32'd4); wr(4'h4, 32'd1); idle(14);
    // R9: continuous with target 1 then 0
    curReq = "R9";
    wr(4'h8, 32'd1); wr(4'h4, 32'd1); idle(6);
    wr(4'h8, 32'd0); wr(4'h4, 32'd1); idle(6);
    // R4: prescaler exponent 2, then 3
    curReq = "R4";
    wr(4'h0, 32'h21); wr(4'h8, 32'd3); wr(4'h4, 32'd1); idle(30);
    wr(4'h0, 32'h30); wr(4'h8, 32'd4); wr(4'h4, 32'd1); idle(40);
    // R5: rising ticks on line 5, other lines ignored
    curReq = "R5";
    wr(4'h0, 32'h0000_0503); wr(4'h8, 32'd3); wr(4'h4, 32'd1);
    for (int k = 0; k < 8; k++) pulseLine(5, k % 3);
    for (int k = 0; k < 6; k++) pulseLine(6, 1);
    idle(3);
    // R5: falling ticks on line 40 with prescaler 2
    wr(4'h0, 32'h0000_6813); wr(4'h4, 32'd1);
    for (int k = 0; k < 16; k++) pulseLine(40, k % 2);
    idle(3);
    // R3: disable holds the count, re-enable restarts
    curReq = "R3";
    wr(4'h0, 32'h1); wr(4'h8, 32'd100); wr(4'h4, 32'd1); idle(7);
    wr(4'h4, 32'd0); idle(6); rd(4'h4); idle(1); rd(4'hC);
    wr(4'h4, 32'd1); idle(4);
    // R10: target changed while running
    curReq = "R10";
    wr(4'h8, 32'd20); wr(4'h4, 32'd1); idle(5);
    wr(4'h8, 32'd3); idle(10);
    wr(4'h0, 32'h0); wr(4'h8, 32'd30); wr(4'h4, 32'd1); idle(4);
    wr(4'h8, 32'd2); idle(6);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule